// File: doc/BRIEF.md
# Dual-Channel Converter Output Stage

This block is the digital back end of a two-channel sampling converter. Each channel delivers a 14-bit raw sample in offset binary together with an out-of-range flag. The block picks the number format from a two-bit code, can exchange which channel appears on which output bus, and merges the two out-of-range flags into one shared overflow output. It also turns each channel's shutdown and output-disable pins into a power state: run, nap or sleep.

Each output bus comes with an enable that says whether the bus is driven or left at high impedance. A channel that leaves nap or sleep keeps its bus undriven and its valid flag low until a wake counter expires. The counter is short after nap and long after sleep, and both lengths are parameters. A forwarded copy of the sample clock is gated off while channel B is powered down. Data is meant to be captured on the falling edge of that clock.

Top module: `dualconv_outstage`

## Requirements
- R1: Bus data is registered and appears one rising clock edge after the sample. Format codes 0 and 1 pass the raw offset-binary value unchanged. Codes 2 and 3 give two's complement, which means the raw value with only bit 13 inverted.
- R2: `duty_fix_en` is high for format codes 1 and 2 and low for codes 0 and 3.
- R3: One edge after either `ovr_a` or `ovr_b` is high, `ovf` is high. When both were low, it is low.
- R4: A channel's power state is decoded from its pins. Shutdown low is run. Shutdown high with disable high is sleep. Shutdown high with disable low is nap. In nap or sleep, that channel's bus enable and valid flag are both low.
- R5: In run, a high disable pin drives that bus's enable low. For channel A the same pin also drives `ovf_oe` low.
- R6: `ovf_oe` is low whenever channel A is in nap or sleep.
- R7: After shutdown is released from nap, the valid flag and bus enable stay low for `NAP_WAKE`-1 rising edges. Both rise after the `NAP_WAKE`-th edge.
- R8: After shutdown is released from sleep, the same holds with `SLEEP_WAKE` edges.
- R9: With `swap_sel` high, bus A carries channel A and bus B carries channel B. With it low, the two are exchanged.
- R10: `fwd_clk` follows `clk` while `shdn_b` is low and is held low while `shdn_b` is high.
- R11: The two channels' power states are independent. One channel in sleep does not disturb the other channel's bus, enable or valid flag.
- R12: After reset with both shutdowns low, both valid flags are high with no wake delay, and the data and `ovf` registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_a | input | 14 | Channel A raw sample, offset binary |
| smp_b | input | 14 | Channel B raw sample, offset binary |
| ovr_a | input | 1 | Channel A out-of-range flag |
| ovr_b | input | 1 | Channel B out-of-range flag |
| shdn_a | input | 1 | Channel A shutdown |
| shdn_b | input | 1 | Channel B shutdown |
| dis_a | input | 1 | Channel A output disable, also selects sleep or nap |
| dis_b | input | 1 | Channel B output disable, also selects sleep or nap |
| swap_sel | input | 1 | High: straight routing; low: buses exchanged |
| fmt_code | input | 2 | Format and duty-stabilizer code |
| bus_a | output | 14 | Output bus A data |
| bus_a_oe | output | 1 | Bus A drive enable (low = high impedance) |
| bus_b | output | 14 | Output bus B data |
| bus_b_oe | output | 1 | Bus B drive enable |
| ovf | output | 1 | Shared overflow flag |
| ovf_oe | output | 1 | Overflow drive enable |
| fwd_clk | output | 1 | Forwarded sample clock |
| valid_a | output | 1 | Channel A awake and its data valid |
| valid_b | output | 1 | Channel B awake and its data valid |
| duty_fix_en | output | 1 | Clock duty-cycle stabilizer request |

## Verification
The wake-hold properties assume that shutdown pins change only between clock edges. They also assume both wake lengths are at least one, so that leaving a low-power state always costs at least one cycle. The overflow property assumes flags are synchronous to `clk`. The bench changes every input at the falling edge, so all values are settled at each rising edge. It keeps the default one-hundred-cycle nap wake and shortens the sleep wake to a few hundred cycles, which lets both wake boundaries be checked edge by edge.

// File: rtl/dco_pkg.sv
package dco_pkg;

  typedef enum logic [1:0] {
    PW_RUN   = 2'd0,
    PW_NAP   = 2'd1,
    PW_SLEEP = 2'd2
  } pwr_e;

  // shutdown low -> run; shutdown high: disable high -> sleep, low -> nap
  function automatic pwr_e pwr_decode(input logic shdn, input logic dis);
    if (!shdn)    return PW_RUN;
    else if (dis) return PW_SLEEP;
    else          return PW_NAP;
  endfunction

  // format code bit 1 picks two's complement
  function automatic logic fmt_is_twos(input logic [1:0] code);
    return code[1];
  endfunction

  // stabilizer requested by the two middle codes
  function automatic logic fmt_stab(input logic [1:0] code);
    return code[1] ^ code[0];
  endfunction

endpackage

// File: rtl/dco_power_ctl.sv
module dco_power_ctl
  import dco_pkg::*;
#(
  parameter int NAP_WAKE   = 100,
  parameter int SLEEP_WAKE = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shdn,
  input  logic dis,
  output logic lowpower,
  output logic ready
);
  localparam int MAXW = (SLEEP_WAKE > NAP_WAKE) ? SLEEP_WAKE : NAP_WAKE;
  localparam int CW   = $clog2(MAXW + 1);

  pwr_e          st;
  logic [CW-1:0] wake_cnt;

  assign st       = pwr_decode(shdn, dis);
  assign lowpower = (st != PW_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wake_cnt <= '0;
    else if (st == PW_SLEEP)    wake_cnt <= CW'(SLEEP_WAKE);
    else if (st == PW_NAP)      wake_cnt <= CW'(NAP_WAKE);
    else if (wake_cnt != '0)    wake_cnt <= wake_cnt - 1'b1;
  end

  assign ready = !lowpower && (wake_cnt == '0);

  AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lowpower) && $past(rst_n)) |-> !ready); // R7

  AST_NO_DIRECT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (!$past(lowpower) || !$past(rst_n))); // R8

endmodule

// File: rtl/dco_lane.sv
module dco_lane #(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pick_first,
  input  logic          twos,
  input  logic [DW-1:0] raw_first,
  input  logic [DW-1:0] raw_second,
  output logic [DW-1:0] data_q
);
  function automatic logic [DW-1:0] fmt_apply(input logic [DW-1:0] raw,
                                               input logic t);
    logic [DW-1:0] r;
    r = raw;
    if (t) r[DW-1] = ~raw[DW-1];
    return r;
  endfunction

  logic [DW-1:0] picked;
  assign picked = pick_first ? raw_first : raw_second;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= fmt_apply(picked, twos);
  end

endmodule

// File: rtl/dualconv_outstage.sv
module dualconv_outstage
  import dco_pkg::*;
#(
  parameter int DW         = 14,
  parameter int NAP_WAKE   = 100,
  parameter int SLEEP_WAKE = 1000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] smp_a,
  input  logic [DW-1:0] smp_b,
  input  logic          ovr_a,
  input  logic          ovr_b,
  input  logic          shdn_a,
  input  logic          shdn_b,
  input  logic          dis_a,
  input  logic          dis_b,
  input  logic          swap_sel,
  input  logic [1:0]    fmt_code,
  output logic [DW-1:0] bus_a,
  output logic          bus_a_oe,
  output logic [DW-1:0] bus_b,
  output logic          bus_b_oe,
  output logic          ovf,
  output logic          ovf_oe,
  output logic          fwd_clk,
  output logic          valid_a,
  output logic          valid_b,
  output logic          duty_fix_en
);
  localparam int NCH = 2;

  logic [NCH-1:0]   shdn_v, dis_v, lp_v, rdy_v;
  logic [DW-1:0]    lane_q [NCH];
  logic             twos;

  assign shdn_v = {shdn_b, shdn_a};
  assign dis_v  = {dis_b, dis_a};
  assign twos   = fmt_is_twos(fmt_code);

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      dco_power_ctl #(.NAP_WAKE(NAP_WAKE), .SLEEP_WAKE(SLEEP_WAKE)) u_pwr (
        .clk(clk), .rst_n(rst_n), .shdn(shdn_v[g]), .dis(dis_v[g]),
        .lowpower(lp_v[g]), .ready(rdy_v[g])
      );
      // lane 0 = bus A (channel A first), lane 1 = bus B (channel B first)
      dco_lane #(.DW(DW)) u_lane (
        .clk(clk), .rst_n(rst_n), .pick_first(swap_sel), .twos(twos),
        .raw_first(g == 0 ? smp_a : smp_b),
        .raw_second(g == 0 ? smp_b : smp_a),
        .data_q(lane_q[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf <= 1'b0;
    else        ovf <= ovr_a | ovr_b;
  end

  assign bus_a       = lane_q[0];
  assign bus_b       = lane_q[1];
  assign bus_a_oe    = rdy_v[0] & ~dis_a;
  assign bus_b_oe    = rdy_v[1] & ~dis_b;
  assign ovf_oe      = rdy_v[0] & ~dis_a;
  assign valid_a     = rdy_v[0];
  assign valid_b     = rdy_v[1];
  assign duty_fix_en = fmt_stab(fmt_code);
  assign fwd_clk     = clk & ~lp_v[1];

  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_a || ovr_b) |=> ovf); // R3

  AST_OVF_HIZ_LP: assert property (@(posedge clk) disable iff (!rst_n)
    lp_v[0] |-> !ovf_oe); // R6

  AST_BUS_HIZ_LP: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_v[0] |-> !bus_a_oe) and (lp_v[1] |-> !bus_b_oe)); // R4

  AST_DIS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_a && !shdn_a) |-> (!bus_a_oe && !ovf_oe)); // R5

endmodule

// File: tb/test_dualconv_outstage.sv
module test_dualconv_outstage;
  localparam int DW  = 14;
  localparam int NW  = 100;
  localparam int SLW = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DW-1:0] smp_a = '0, smp_b = '0;
  logic ovr_a = 0, ovr_b = 0, shdn_a = 0, shdn_b = 0, dis_a = 0, dis_b = 0;
  logic swap_sel = 1'b1;
  logic [1:0] fmt_code = 2'd0;
  logic [DW-1:0] bus_a, bus_b;
  logic bus_a_oe, bus_b_oe, ovf, ovf_oe, fwd_clk, valid_a, valid_b, duty_fix_en;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  dualconv_outstage #(.DW(DW), .NAP_WAKE(NW), .SLEEP_WAKE(SLW)) i_dualconv_outstage (
    .clk(clk), .rst_n(rst_n), .smp_a(smp_a), .smp_b(smp_b), .ovr_a(ovr_a), .ovr_b(ovr_b),
    .shdn_a(shdn_a), .shdn_b(shdn_b), .dis_a(dis_a), .dis_b(dis_b), .swap_sel(swap_sel),
    .fmt_code(fmt_code), .bus_a(bus_a), .bus_a_oe(bus_a_oe), .bus_b(bus_b),
    .bus_b_oe(bus_b_oe), .ovf(ovf), .ovf_oe(ovf_oe), .fwd_clk(fwd_clk),
    .valid_a(valid_a), .valid_b(valid_b), .duty_fix_en(duty_fix_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] to_twos(input logic [DW-1:0] v);
    return v ^ (14'h1 << (DW - 1));
  endfunction

  task automatic t_reset();
    step(); step();
    check("R12 bus_a in reset", bus_a, 0);
    check("R12 ovf in reset", ovf, 0);
    rst_n = 1'b1;
    step();
    check("R12 valid_a after reset", valid_a, 1);
    check("R12 valid_b after reset", valid_b, 1);
  endtask

  task automatic t_format();
    smp_a = 14'h2ABC; smp_b = 14'h0123; swap_sel = 1'b1;
    for (int c = 0; c < 4; c++) begin
      fmt_code = 2'(c);
      step();
      check("R1 bus_a format", bus_a, (c >= 2) ? to_twos(14'h2ABC) : 14'h2ABC);
      check("R1 bus_b format", bus_b, (c >= 2) ? to_twos(14'h0123) : 14'h0123);
      check("R2 duty_fix_en", duty_fix_en, (c == 1 || c == 2) ? 1 : 0);
    end
    fmt_code = 2'd0;
  endtask

  task automatic t_overflow();
    ovr_a = 1; ovr_b = 0; step(); check("R3 ovf from A", ovf, 1);
    ovr_a = 0; ovr_b = 1; step(); check("R3 ovf from B", ovf, 1);
    ovr_a = 0; ovr_b = 0; step(); check("R3 ovf clear", ovf, 0);
    check("R5 ovf_oe in run", ovf_oe, 1);
  endtask

  task automatic t_swap();
    smp_a = 14'h1111; smp_b = 14'h3EEE; swap_sel = 1'b0; step();
    check("R9 swapped bus_a", bus_a, 14'h3EEE);
    check("R9 swapped bus_b", bus_b, 14'h1111);
    swap_sel = 1'b1; step();
    check("R9 straight bus_a", bus_a, 14'h1111);
    check("R9 straight bus_b", bus_b, 14'h3EEE);
  endtask

  task automatic t_disable();
    dis_a = 1; step();
    check("R5 bus_a_oe disabled", bus_a_oe, 0);
    check("R5 ovf_oe disabled", ovf_oe, 0);
    check("R5 valid_a stays", valid_a, 1);
    dis_a = 0; dis_b = 1; step();
    check("R5 bus_b_oe disabled", bus_b_oe, 0);
    check("R5 bus_a_oe back", bus_a_oe, 1);
    dis_b = 0; step();
  endtask

  task automatic t_nap_wake();
    shdn_a = 1; dis_a = 0; step(); step();
    check("R4 nap bus_a_oe", bus_a_oe, 0);
    check("R4 nap valid_a", valid_a, 0);
    check("R6 nap ovf_oe", ovf_oe, 0);
    shdn_a = 0;
    for (int i = 1; i <= NW; i++) begin
      step();
      if (i == NW - 1) begin
        check("R7 valid_a before nap wake", valid_a, 0);
        check("R7 bus_a_oe before nap wake", bus_a_oe, 0);
      end
      if (i == NW) begin
        check("R7 valid_a at nap wake", valid_a, 1);
        check("R7 bus_a_oe at nap wake", bus_a_oe, 1);
      end
    end
  endtask

  task automatic t_sleep_wake();
    shdn_a = 1; dis_a = 1; step(); step();
    check("R4 sleep bus_a_oe", bus_a_oe, 0);
    check("R6 sleep ovf_oe", ovf_oe, 0);
    shdn_a = 0; dis_a = 0;
    for (int i = 1; i <= SLW; i++) begin
      step();
      if (i == NW) check("R8 still asleep past nap length", valid_a, 0);
      if (i == SLW - 1) check("R8 valid_a before sleep wake", valid_a, 0);
      if (i == SLW) check("R8 valid_a at sleep wake", valid_a, 1);
    end
  endtask

  task automatic t_independent();
    shdn_b = 1; dis_b = 1; smp_a = 14'h0555; step();
    check("R11 B asleep valid_b", valid_b, 0);
    check("R11 A still valid", valid_a, 1);
    check("R11 A bus enabled", bus_a_oe, 1);
    check("R11 A data flows", bus_a, 14'h0555);
    @(posedge clk); #1;
    check("R10 fwd_clk held low", fwd_clk, 0);
    @(negedge clk);
    shdn_b = 0; dis_b = 0; step();
    @(posedge clk); #1;
    check("R10 fwd_clk follows high phase", fwd_clk, 1);
    @(negedge clk); #1;
    check("R10 fwd_clk follows low phase", fwd_clk, 0);
    @(negedge clk);
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_format();
    t_overflow();
    t_swap();
    t_disable();
    t_nap_wake();
    t_sleep_wake();
    t_independent();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule